// File: doc/BRIEF.md
# UART Register File with Receive FIFO

This block is the register side of a UART-style peripheral on a plain 32-bit bus. The bus presents a word index, a select, a write strobe and write data in one cycle. Reads return data in the same cycle, and any side effect of an access takes effect at the next clock edge. The block holds the configuration registers: control, line control, integer and fractional baud divisors, low-power divisor, FIFO level select, interrupt mask and DMA control. It also holds a 16-entry receive FIFO that a byte-wide input port fills.

Software drains the FIFO through the data register. Writing the data register sends the low byte out on a strobe-plus-byte port one cycle later. A raw interrupt status register records transmit and receive events. The masked view of that status drives a single interrupt line, and software clears status bits with a write-one-to-clear register. A flag register reports FIFO empty and full. A receive status register keeps a sticky overrun bit. Eight read-only words hold identification bytes.

Accesses to unmapped indices, writes to read-only indices, and DMA-control writes that request a DMA mode raise a same-cycle error output. Serial bit timing, transmit queuing and DMA transfers are not handled here.

Top module: `uartrf_top`

## Requirements
- R1: After reset the flag word (index 6) reads 0x90, control (index 12) reads 0x300 and FIFO level select (index 13) reads 0x12. Every other register reads 0, `irq` is low and `tx_strobe` is low.
- R2: The low-power divisor (8), integer divisor (9), fractional divisor (10), line control (11), control (12), level select (13), mask (14) and DMA control (18) read back the last value written to them.
- R3: Each accepted `rx_valid` byte enters the FIFO and clears the empty flag (flag bit 4). Reads of index 0 return the bytes in arrival order, zero-extended. The empty flag sets again when the last byte is read.
- R4: The full flag (flag bit 6) sets on any received byte while the FIFO-enable bit (line control bit 4) is 0. While that bit is 1, it sets when the count reaches 16. Any read of index 0 clears it.
- R5: A byte that arrives while 16 bytes are held is dropped and sets the sticky overrun bit (bit 3 of index 1). Any write to index 1 clears that bit.
- R6: The receive interrupt (raw status bit 4) sets when a byte lands and the count is at least the trigger level of 1. It clears when a read of index 0 leaves the count one below the trigger level.
- R7: A write to index 0 pulses `tx_strobe` for one cycle on the next cycle, with `tx_byte` equal to write data bits 7:0, and sets raw status bit 5.
- R8: Index 15 reads the raw status and index 16 reads raw AND mask. `irq` is high exactly when that masked value is non-zero. A write to index 17 clears each raw bit that is 1 in the written value.
- R9: A line-control write that flips bit 4 empties the FIFO: the empty flag sets, the full flag clears, and the following data read returns 0. A line-control write that leaves bit 4 unchanged keeps the stored bytes.
- R10: Writes to the flag word (index 6) leave its value unchanged.
- R11: Indices 0x3F8 through 0x3FF read the identification bytes 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, zero-extended, without error.
- R12: `bus_err` is high during a DMA-control write whose bits 1:0 are not both 0 (the value is still stored). It is also high during a read of an index other than 0, 1, 6, 8–16, 18 or the identification words, and during a write to an index other than 0, 1, 6, 8–14, 17 or 18. A rejected read returns 0. A write to index 6 raises no error.
- R13: A read of index 0 while the FIFO is empty returns 0 and leaves the count at 0, so the next received byte is the next one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 11 | Word index (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Access error, valid in the access cycle |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_strobe | output | 1 | One-cycle pulse carrying a transmit byte |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt, OR of the masked status |

## Verification
The receive path is driven with three patterns:
- A short burst of three bytes with the FIFO enabled. This separates ordering and empty-flag behaviour from the full-flag threshold.
- Sixteen bytes followed by one extra byte. This separates the full threshold from overrun dropping, and confirms that the dropped byte never appears.
- Single bytes with the FIFO disabled. This separates the full-flag meaning in that mode from depth-based fullness.

Line-control writes are tried both with and without a change to the enable bit, which tells a flush apart from a plain register update. Data reads on an empty FIFO are followed by a fresh byte, which shows that no phantom entry was counted. A vector table sweeps reset values, readback, identification words and error decoding across mapped, read-only and unmapped indices.

// File: rtl/uartrf_pkg.sv
package uartrf_pkg;
  localparam int REG_W = 32;
  localparam int IDX_W = 11;
  localparam int IRQ_W = 11;
  localparam int BYTE_W = 8;

  typedef logic [IDX_W-1:0] idx_t;

  // word indices; the order matters only to software
  localparam idx_t IX_DATA   = idx_t'(0);
  localparam idx_t IX_RXSTAT = idx_t'(1);
  localparam idx_t IX_FLAG   = idx_t'(6);
  localparam idx_t IX_LOWPWR = idx_t'(8);
  localparam idx_t IX_DIVI   = idx_t'(9);
  localparam idx_t IX_DIVF   = idx_t'(10);
  localparam idx_t IX_LINE   = idx_t'(11);
  localparam idx_t IX_CTRL   = idx_t'(12);
  localparam idx_t IX_LEVEL  = idx_t'(13);
  localparam idx_t IX_MASK   = idx_t'(14);
  localparam idx_t IX_RAW    = idx_t'(15);
  localparam idx_t IX_MSK    = idx_t'(16);
  localparam idx_t IX_CLR    = idx_t'(17);
  localparam idx_t IX_DMA    = idx_t'(18);
  localparam idx_t IX_ID_LO  = idx_t'(11'h3F8);
  localparam idx_t IX_ID_HI  = idx_t'(11'h3FF);

  localparam int IRQ_RX_BIT = 4;
  localparam int IRQ_TX_BIT = 5;
  localparam int FLG_EMPTY  = 4;
  localparam int FLG_FULL   = 6;
  localparam int FLG_TXE    = 7;
  localparam int LINE_FEN   = 4;
  localparam int RXS_OVR    = 3;

  localparam logic [REG_W-1:0] CTRL_RST  = REG_W'(32'h300);
  localparam logic [REG_W-1:0] LEVEL_RST = REG_W'(32'h12);

  function automatic logic id_hit(input idx_t ix);
    return (ix >= IX_ID_LO) && (ix <= IX_ID_HI);
  endfunction

  function automatic logic [BYTE_W-1:0] ident_byte(input logic [2:0] k);
    case (k)
      3'd0: return 8'h11;
      3'd1: return 8'h10;
      3'd2: return 8'h14;
      3'd3: return 8'h00;
      3'd4: return 8'h0D;
      3'd5: return 8'hF0;
      3'd6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

  function automatic logic idx_readable(input idx_t ix);
    case (ix)
      IX_DATA, IX_RXSTAT, IX_FLAG, IX_LOWPWR, IX_DIVI, IX_DIVF, IX_LINE,
      IX_CTRL, IX_LEVEL, IX_MASK, IX_RAW, IX_MSK, IX_DMA: return 1'b1;
      default: return id_hit(ix);
    endcase
  endfunction

  function automatic logic idx_writable(input idx_t ix);
    case (ix)
      IX_DATA, IX_RXSTAT, IX_FLAG, IX_LOWPWR, IX_DIVI, IX_DIVF, IX_LINE,
      IX_CTRL, IX_LEVEL, IX_MASK, IX_CLR, IX_DMA: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // DMA request bits may not be set: no DMA engine behind this block
  function automatic logic dma_request(input logic [REG_W-1:0] v);
    return |v[1:0];
  endfunction
endpackage

// File: rtl/uartrf_rx_fifo.sv
module uartrf_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push_req,
  input  logic [W-1:0]  din,
  input  logic          pop_req,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          push_ok,
  output logic          pop_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign pop_ok  = pop_req && (cnt_q != '0) && !flush;
  assign push_ok = push_req && !flush && ((cnt_q < CW'(DEPTH)) || pop_ok);
  assign head    = mem[rp_q];
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= ptr_inc(wp_q);
      if (pop_ok)  rp_q <= ptr_inc(rp_q);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/uartrf_irq_ctrl.sv
module uartrf_irq_ctrl
  import uartrf_pkg::*;
#(
  parameter int W = IRQ_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_tx,
  input  logic         set_rx,
  input  logic         clr_rx,
  input  logic         clr_en,
  input  logic [W-1:0] clr_val,
  input  logic         mask_en,
  input  logic [W-1:0] mask_val,
  output logic [W-1:0] raw,
  output logic [W-1:0] mask,
  output logic [W-1:0] masked,
  output logic         irq
);
  logic [W-1:0] raw_q, mask_q, raw_d;

  // new events win over a clear arriving in the same cycle
  always_comb begin
    raw_d = raw_q;
    if (clr_en) raw_d = raw_d & ~clr_val;
    if (clr_rx) raw_d[IRQ_RX_BIT] = 1'b0;
    if (set_tx) raw_d[IRQ_TX_BIT] = 1'b1;
    if (set_rx) raw_d[IRQ_RX_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= raw_d;
      if (mask_en) mask_q <= mask_val;
    end
  end

  assign raw    = raw_q;
  assign mask   = mask_q;
  assign masked = raw_q & mask_q;
  assign irq    = |masked;
endmodule

// File: rtl/uartrf_top.sv
module uartrf_top
  import uartrf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [IDX_W-1:0]  bus_idx,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_err,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);
  // access decode
  logic rd_acc, wr_acc;
  assign rd_acc = bus_sel && !bus_wr;
  assign wr_acc = bus_sel && bus_wr;

  logic dr_read, dr_write, rxs_write, line_write, level_write;
  logic mask_write, clr_write;
  assign dr_read     = rd_acc && (bus_idx == IX_DATA);
  assign dr_write    = wr_acc && (bus_idx == IX_DATA);
  assign rxs_write   = wr_acc && (bus_idx == IX_RXSTAT);
  assign line_write  = wr_acc && (bus_idx == IX_LINE);
  assign level_write = wr_acc && (bus_idx == IX_LEVEL);
  assign mask_write  = wr_acc && (bus_idx == IX_MASK);
  assign clr_write   = wr_acc && (bus_idx == IX_CLR);

  // configuration storage
  logic [REG_W-1:0] lowpwr_q, divi_q, divf_q, line_q, ctrl_q, level_q, dma_q;
  logic [CW-1:0]    trig_q;
  logic             fifo_en;
  assign fifo_en = line_q[LINE_FEN];

  logic fifo_flush;
  assign fifo_flush = line_write && (bus_wdata[LINE_FEN] != fifo_en);

  // receive FIFO
  logic [BYTE_W-1:0] rx_head;
  logic [CW-1:0]     rx_count, cnt_next;
  logic              push_ok, pop_ok;

  uartrf_rx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(fifo_flush),
    .push_req(rx_valid), .din(rx_byte), .pop_req(dr_read),
    .head(rx_head), .count(rx_count), .push_ok(push_ok), .pop_ok(pop_ok)
  );

  assign cnt_next = rx_count + CW'(push_ok) - CW'(pop_ok);

  logic rx_set, rx_clr, rx_drop;
  assign rx_set  = push_ok && (cnt_next >= trig_q);
  assign rx_clr  = dr_read && !fifo_flush && (cnt_next == trig_q - CW'(1)) && !rx_set;
  assign rx_drop = rx_valid && !push_ok && !fifo_flush;

  // flags and receive status
  logic full_q, empty_q, ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      ovr_q   <= 1'b0;
    end else begin
      if (fifo_flush) begin
        full_q  <= 1'b0;
        empty_q <= 1'b1;
      end else if (push_ok) begin
        full_q  <= !fifo_en || (cnt_next == CW'(DEPTH));
        empty_q <= 1'b0;
      end else if (dr_read) begin
        full_q  <= 1'b0;
        if (cnt_next == '0) empty_q <= 1'b1;
      end
      if (rx_drop)        ovr_q <= 1'b1;
      else if (rxs_write) ovr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowpwr_q <= '0;
      divi_q   <= '0;
      divf_q   <= '0;
      line_q   <= '0;
      ctrl_q   <= CTRL_RST;
      level_q  <= LEVEL_RST;
      dma_q    <= '0;
      trig_q   <= CW'(1);
    end else if (wr_acc) begin
      case (bus_idx)
        IX_LOWPWR: lowpwr_q <= bus_wdata;
        IX_DIVI:   divi_q   <= bus_wdata;
        IX_DIVF:   divf_q   <= bus_wdata;
        IX_CTRL:   ctrl_q   <= bus_wdata;
        IX_DMA:    dma_q    <= bus_wdata;
        default: ;
      endcase
      if (line_write)  line_q  <= bus_wdata;
      if (level_write) level_q <= bus_wdata;
      if (line_write || level_write) trig_q <= CW'(1);
    end
  end

  // interrupts
  logic [IRQ_W-1:0] irq_raw, irq_mask, irq_masked;

  uartrf_irq_ctrl #(.W(IRQ_W)) irq_i (
    .clk(clk), .rst_n(rst_n),
    .set_tx(dr_write), .set_rx(rx_set), .clr_rx(rx_clr),
    .clr_en(clr_write), .clr_val(bus_wdata[IRQ_W-1:0]),
    .mask_en(mask_write), .mask_val(bus_wdata[IRQ_W-1:0]),
    .raw(irq_raw), .mask(irq_mask), .masked(irq_masked), .irq(irq)
  );

  // transmit port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
    end else begin
      tx_strobe <= dr_write;
      if (dr_write) tx_byte <= bus_wdata[BYTE_W-1:0];
    end
  end

  // read path and error
  logic [REG_W-1:0] flag_word, rxs_word;
  always_comb begin
    flag_word            = '0;
    flag_word[FLG_TXE]   = 1'b1;
    flag_word[FLG_FULL]  = full_q;
    flag_word[FLG_EMPTY] = empty_q;
    rxs_word             = '0;
    rxs_word[RXS_OVR]    = ovr_q;
  end

  logic rd_ok;
  assign rd_ok = idx_readable(bus_idx);

  always_comb begin
    bus_rdata = '0;
    if (rd_acc && rd_ok) begin
      case (bus_idx)
        IX_DATA:   bus_rdata = (rx_count != '0) ? REG_W'(rx_head) : '0;
        IX_RXSTAT: bus_rdata = rxs_word;
        IX_FLAG:   bus_rdata = flag_word;
        IX_LOWPWR: bus_rdata = lowpwr_q;
        IX_DIVI:   bus_rdata = divi_q;
        IX_DIVF:   bus_rdata = divf_q;
        IX_LINE:   bus_rdata = line_q;
        IX_CTRL:   bus_rdata = ctrl_q;
        IX_LEVEL:  bus_rdata = level_q;
        IX_MASK:   bus_rdata = REG_W'(irq_mask);
        IX_RAW:    bus_rdata = REG_W'(irq_raw);
        IX_MSK:    bus_rdata = REG_W'(irq_masked);
        IX_DMA:    bus_rdata = dma_q;
        default:   bus_rdata = REG_W'(ident_byte(bus_idx[2:0]));
      endcase
    end
  end

  assign bus_err = (rd_acc && !rd_ok) ||
                   (wr_acc && (!idx_writable(bus_idx) ||
                               ((bus_idx == IX_DMA) && dma_request(bus_wdata))));
endmodule

// File: rtl/uartrf_chk.sv
module uartrf_chk
  import uartrf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [IDX_W-1:0]  bus_idx,
  input logic [REG_W-1:0]  bus_wdata,
  input logic              bus_err,
  input logic              tx_strobe,
  input logic [BYTE_W-1:0] tx_byte,
  input logic              rx_valid,
  input logic              push_ok,
  input logic              dr_read,
  input logic              fifo_flush,
  input logic [CW-1:0]     rx_count,
  input logic              empty_q,
  input logic              full_q,
  input logic              ovr_q,
  input logic              fifo_en,
  input logic [IRQ_W-1:0]  irq_raw
);
  assert_tx_follows_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_idx == IX_DATA) |=> (tx_strobe && tx_byte == $past(bus_wdata[BYTE_W-1:0])));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));

  assert_drop_sets_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_count == CW'(DEPTH) && !dr_read && !fifo_flush) |=> ovr_q);

  assert_empty_tracks_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    empty_q == (rx_count == '0));

  assert_full_at_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && fifo_en) |-> (rx_count == CW'(DEPTH)));

  assert_rx_irq_on_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> irq_raw[IRQ_RX_BIT]);

  assert_ident_no_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && id_hit(bus_idx)) |-> !bus_err);

  assert_dma_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_idx == IX_DMA && bus_wdata[1:0] != 2'b00) |-> bus_err);
endmodule

bind uartrf_top uartrf_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_err(bus_err),
  .tx_strobe(tx_strobe), .tx_byte(tx_byte), .rx_valid(rx_valid),
  .push_ok(push_ok), .dr_read(dr_read), .fifo_flush(fifo_flush),
  .rx_count(rx_count), .empty_q(empty_q), .full_q(full_q), .ovr_q(ovr_q),
  .fifo_en(fifo_en), .irq_raw(irq_raw)
);

// File: tb/uartrf_tb.sv
module uartrf_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 35;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [10:0] bus_idx = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_strobe;
  logic [7:0]  tx_byte;
  logic        irq;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uartrf_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
  );

  // vector: {write, index[10:0], wdata[31:0], expected read[31:0], expected err}
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 11'h006, 32'h0, 32'h90,  1'b0},  // R1 flags
    {1'b0, 11'h00C, 32'h0, 32'h300, 1'b0},  // R1 control
    {1'b0, 11'h00D, 32'h0, 32'h12,  1'b0},  // R1 level
    {1'b0, 11'h00B, 32'h0, 32'h0,   1'b0},  // R1 line
    {1'b0, 11'h00E, 32'h0, 32'h0,   1'b0},  // R1 mask
    {1'b0, 11'h00F, 32'h0, 32'h0,   1'b0},  // R1 raw
    {1'b0, 11'h001, 32'h0, 32'h0,   1'b0},  // R1 rx status
    {1'b0, 11'h012, 32'h0, 32'h0,   1'b0},  // R1 dma
    {1'b0, 11'h009, 32'h0, 32'h0,   1'b0},  // R1 divisor
    {1'b1, 11'h009, 32'h1A, 32'h0,  1'b0},  // R2 writes
    {1'b1, 11'h00A, 32'h05, 32'h0,  1'b0},
    {1'b1, 11'h008, 32'h33, 32'h0,  1'b0},
    {1'b1, 11'h00C, 32'h301, 32'h0, 1'b0},
    {1'b1, 11'h00D, 32'h09, 32'h0,  1'b0},
    {1'b1, 11'h012, 32'h04, 32'h0,  1'b0},
    {1'b0, 11'h009, 32'h0, 32'h1A,  1'b0},  // R2 readback
    {1'b0, 11'h00A, 32'h0, 32'h05,  1'b0},
    {1'b0, 11'h008, 32'h0, 32'h33,  1'b0},
    {1'b0, 11'h00C, 32'h0, 32'h301, 1'b0},
    {1'b0, 11'h00D, 32'h0, 32'h09,  1'b0},
    {1'b0, 11'h012, 32'h0, 32'h04,  1'b0},
    {1'b1, 11'h012, 32'h01, 32'h0,  1'b1},  // R12 dma request
    {1'b0, 11'h012, 32'h0, 32'h01,  1'b0},  // R12 stored anyway
    {1'b1, 11'h006, 32'hFF, 32'h0,  1'b0},  // R10 flag write
    {1'b0, 11'h006, 32'h0, 32'h90,  1'b0},  // R10 unchanged
    {1'b0, 11'h002, 32'h0, 32'h0,   1'b1},  // R12 unmapped read
    {1'b1, 11'h003, 32'h7, 32'h0,   1'b1},  // R12 unmapped write
    {1'b0, 11'h011, 32'h0, 32'h0,   1'b1},  // R12 clear reg read
    {1'b1, 11'h00F, 32'h7, 32'h0,   1'b1},  // R12 raw write
    {1'b0, 11'h3F8, 32'h0, 32'h11,  1'b0},  // R11 ident
    {1'b0, 11'h3FB, 32'h0, 32'h00,  1'b0},
    {1'b0, 11'h3FC, 32'h0, 32'h0D,  1'b0},
    {1'b0, 11'h3FF, 32'h0, 32'hB1,  1'b0},
    {1'b0, 11'h400, 32'h0, 32'h0,   1'b1},  // R12 past ident range
    {1'b1, 11'h012, 32'h0, 32'h0,   1'b0}   // R2 restore dma
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [10:0] ix, input logic [31:0] d, output logic err);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_idx = ix; bus_wdata = d;
    #1 err = bus_err;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [10:0] ix, output logic [31:0] d, output logic err);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_idx = ix;
    #1 d = bus_rdata; err = bus_err;
    @(posedge clk);
    #1 bus_sel = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(posedge clk);
    #1 rx_valid = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [10:0] ix, input logic [31:0] exp);
    logic [31:0] d;
    logic e;
    bus_read(ix, d, e);
    check(tag, d, exp);
  endtask

  task automatic wr(input logic [10:0] ix, input logic [31:0] d);
    logic e;
    bus_write(ix, d, e);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic e;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 tx_strobe after reset", {31'b0, tx_strobe}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) begin
        bus_write(VEC[i][75:65], VEC[i][64:33], e);
      end else begin
        bus_read(VEC[i][75:65], d, e);
        check($sformatf("R1/R2/R11 table %0d rdata", i), d, VEC[i][32:1]);
      end
      check($sformatf("R12 table %0d err", i), {31'b0, e}, {31'b0, VEC[i][0]});
    end

    // R7 transmit
    bus_write(11'd0, 32'h1A5, e);
    check("R7 tx_strobe", {31'b0, tx_strobe}, 32'h1);
    check("R7 tx_byte", {24'b0, tx_byte}, 32'hA5);
    @(posedge clk); #1;
    check("R7 single pulse", {31'b0, tx_strobe}, 32'h0);
    rd_chk("R7 raw tx bit", 11'd15, 32'h20);
    check("R8 irq masked off", {31'b0, irq}, 32'h0);
    wr(11'd14, 32'h20);
    check("R8 irq on mask", {31'b0, irq}, 32'h1);
    rd_chk("R8 masked status", 11'd16, 32'h20);
    rd_chk("R2 mask readback", 11'd14, 32'h20);
    wr(11'd17, 32'h20);
    rd_chk("R8 clear raw", 11'd15, 32'h0);
    check("R8 irq after clear", {31'b0, irq}, 32'h0);
    wr(11'd14, 32'h10);

    // R3 / R6 short burst, FIFO enabled
    wr(11'd11, 32'h10);
    push(8'h61); push(8'h62); push(8'h63);
    rd_chk("R3 flags not empty", 11'd6, 32'h80);
    rd_chk("R6 rx raw set", 11'd15, 32'h10);
    check("R8 irq rx", {31'b0, irq}, 32'h1);
    rd_chk("R3 first byte", 11'd0, 32'h61);
    rd_chk("R3 second byte", 11'd0, 32'h62);
    rd_chk("R6 rx raw held", 11'd15, 32'h10);
    rd_chk("R3 third byte", 11'd0, 32'h63);
    rd_chk("R3 flags empty", 11'd6, 32'h90);
    rd_chk("R6 rx raw cleared", 11'd15, 32'h0);
    check("R8 irq low", {31'b0, irq}, 32'h0);

    // R4 / R5 fill to depth then overrun
    for (int i = 0; i < 16; i++) push(8'h30 + 8'(i));
    rd_chk("R4 full at 16", 11'd6, 32'hC0);
    push(8'hEE);
    rd_chk("R5 overrun set", 11'd1, 32'h08);
    rd_chk("R5 oldest kept", 11'd0, 32'h30);
    rd_chk("R4 full cleared by read", 11'd6, 32'h80);
    for (int i = 1; i < 16; i++) rd_chk("R5 order after drop", 11'd0, 32'h30 + 32'(i));
    rd_chk("R3 empty again", 11'd6, 32'h90);

    // R13 empty read
    rd_chk("R13 empty read", 11'd0, 32'h0);
    rd_chk("R13 flags stay empty", 11'd6, 32'h90);
    push(8'h55);
    rd_chk("R13 no phantom entry", 11'd0, 32'h55);
    rd_chk("R5 overrun sticky", 11'd1, 32'h08);
    wr(11'd1, 32'h0);
    rd_chk("R5 overrun cleared", 11'd1, 32'h0);

    // R9 line writes with and without enable change
    push(8'h41); push(8'h42);
    wr(11'd11, 32'h12);
    rd_chk("R9 no flush same enable", 11'd0, 32'h41);
    rd_chk("R2 line readback", 11'd11, 32'h12);
    wr(11'd11, 32'h02);
    rd_chk("R9 flush flags", 11'd6, 32'h90);
    rd_chk("R9 flushed read", 11'd0, 32'h0);
    rd_chk("R9 rx raw after empty read", 11'd15, 32'h0);

    // R4 FIFO disabled: one byte sets full
    push(8'h77);
    rd_chk("R4 full when disabled", 11'd6, 32'hC0);
    rd_chk("R6 rx raw disabled mode", 11'd15, 32'h10);
    rd_chk("R4 byte disabled mode", 11'd0, 32'h77);
    rd_chk("R4 full cleared", 11'd6, 32'h90);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule